// File: doc/BRIEF.md
# RTC Periodic Interrupt Rate and Event Status

This block turns a 32.768 kHz time-base enable into a programmable periodic event. It collects that event together with alarm and update-ended pulses from the calendar core into three sticky status flags, and drives a single interrupt line. A byte-wide register bus gives access to three registers. The rate register holds the 4-bit rate code and a prescaler-hold bit. The gate register holds one permit bit per event source. The status register returns the flags and clears them when read.

The prescaler has a two-state machine. PS_HOLD is entered on the clock after the hold bit is seen set; the counter is zero and no periodic events occur. PS_RUN is entered on the clock after the hold bit is seen clear. While the hold bit is set, the counter is also forced to zero in either state, so the hold takes effect immediately. The transitions are HOLD_TO_RUN (hold bit clear) and RUN_TO_HOLD (hold bit set). The periodic event fires on a time-base tick that completes a full period of the selected length.

Top module: `rtc_pi_top`

## Requirements
- R1: After reset the rate register, the gate register and all status flags read 0x00, and `irq` is low.
- R2: Rate codes 3 to 15 give a periodic event every 2^(code-1) time-base ticks: code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R3: Rate code 1 gives 128 ticks and rate code 2 gives 256 ticks. These are the same periods as codes 8 and 9.
- R4: Rate code 0 produces no periodic event.
- R5: While bit 6 of the rate register (offset 0x0A) is set, the prescaler is held at zero and no periodic event occurs. Ticks in the first clock after the releasing write are not counted, so the first event comes a full period after counting resumes.
- R6: In the status register (offset 0x0C), bit 6 is set by a periodic event, bit 5 by an alarm pulse and bit 4 by an update-ended pulse. These flags set whatever the gate bits are.
- R7: In the gate register (offset 0x0B), bits 6, 5 and 4 permit the periodic, alarm and update flags respectively. `irq` and status bit 7 are high exactly when some flag is set and its permit bit is 1.
- R8: A read of the status register returns the current flags and clears all of them on that clock edge. An event arriving in the same clock as the read stays set.
- R9: The rate register reads back bits 3:0 and bit 6 and the gate register reads back bits 6:4, with all other bits 0. A write to the status register has no effect. `bus_rdata` is 0 when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-clock enable per 32.768 kHz time-base period |
| alarm_evt | input | 1 | Alarm-match pulse from the calendar core |
| update_evt | input | 1 | Update-ended pulse from the calendar core |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Merged interrupt, high while a permitted flag is set |

## Verification
A register write, an event pulse or a qualifying tick is taken at the clock edge where it is presented. From the following half cycle, `irq` and the read data reflect it. Read data is combinational, so it is valid in the same cycle as `bus_rd`, and the clear caused by a status read appears in the next cycle. Clearing the hold bit adds one extra clock before counting resumes. The bench drives inputs 2 ns after each rising edge and compares every output against its behavioural model at the falling edge. For the directed period checks, the time base is stopped around the releasing write so that the measured tick count equals the period exactly.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 8;
    localparam logic [BUS_AW-1:0] OFS_RATE = 4'hA;
    localparam logic [BUS_AW-1:0] OFS_GATE = 4'hB;
    localparam logic [BUS_AW-1:0] OFS_STAT = 4'hC;

    typedef enum logic [0:0] {
        PS_HOLD = 1'b0,
        PS_RUN  = 1'b1
    } ps_state_e;

    typedef struct packed {
        logic periodic;
        logic alarm;
        logic update;
    } evt_t;

    // number of low prescaler bits that span one period; 0 means off
    function automatic int unsigned rate_shift(input logic [3:0] code);
        int unsigned s;
        unique case (code)
            4'd0:    s = 0;
            4'd1:    s = 7;
            4'd2:    s = 8;
            default: s = int'(code) - 1;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/rtc_pi_prescaler.sv
module rtc_pi_prescaler
    import rtc_pi_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic [3:0] rate,
    output logic       pev
);
    localparam logic [DIV_W-1:0] ONES = {DIV_W{1'b1}};

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask;
    int unsigned      shift;
    logic             run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HOLD: if (!hold) state_d = PS_RUN;
            PS_RUN:  if (hold)  state_d = PS_HOLD;
            default: state_d = PS_HOLD;
        endcase
    end

    always_comb begin
        shift = rate_shift(rate);
        if (shift > DIV_W) shift = DIV_W;
        mask  = ~(ONES << shift);
        run   = (state_q == PS_RUN) && !hold;
        pev   = run && tick && (shift != 0) && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_pi_regs.sv
module rtc_pi_regs
    import rtc_pi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [BUS_DW-1:0] stat_byte,
    output logic [BUS_DW-1:0] rdata,
    output logic [3:0]        rate,
    output logic              hold,
    output logic [2:0]        gate,
    output logic              stat_clr
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[7], wdata[5:4]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate <= '0;
            hold <= 1'b0;
            gate <= '0;
        end else if (wr) begin
            if (addr == OFS_RATE) begin
                rate <= wdata[3:0];
                hold <= wdata[6];
            end
            if (addr == OFS_GATE) gate <= wdata[6:4];
        end
    end

    always_comb begin
        rdata    = '0;
        stat_clr = rd && (addr == OFS_STAT);
        if (rd) begin
            unique case (addr)
                OFS_RATE: rdata = {1'b0, hold, 2'b00, rate};
                OFS_GATE: rdata = {1'b0, gate, 4'b0000};
                OFS_STAT: rdata = stat_byte;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_pi_status.sv
module rtc_pi_status
    import rtc_pi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              set,
    input  logic              clr,
    input  logic [2:0]        gate,
    output evt_t              flags,
    output logic              irq,
    output logic [BUS_DW-1:0] stat_byte
);
    logic [2:0] set_v, flg_v;
    assign set_v = set;

    for (genvar i = 0; i < 3; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flg_v[i] <= 1'b0;
            else if (set_v[i]) flg_v[i] <= 1'b1;
            else if (clr)    flg_v[i] <= 1'b0;
        end
    end

    always_comb begin
        flags     = flg_v;
        irq       = |(flg_v & gate);
        stat_byte = {irq, flg_v, 4'b0000};
    end
endmodule

// File: rtl/rtc_pi_top.sv
module rtc_pi_top
    import rtc_pi_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       alarm_evt,
    input  logic       update_evt,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    logic [3:0] rate;
    logic       hold;
    logic [2:0] gate;
    logic       stat_clr;
    logic       pev;
    logic [7:0] stat_byte;
    evt_t       set, flags;

    assign set = '{periodic: pev, alarm: alarm_evt, update: update_evt};

    rtc_pi_regs u_regs (
        .clk, .rst_n,
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
        .stat_byte, .rdata(bus_rdata),
        .rate, .hold, .gate, .stat_clr
    );

    rtc_pi_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk, .rst_n, .tick(tick_32k), .hold, .rate, .pev
    );

    rtc_pi_status u_stat (
        .clk, .rst_n, .set, .clr(stat_clr), .gate,
        .flags, .irq, .stat_byte
    );
endmodule

// File: rtl/rtc_pi_chk.sv
module rtc_pi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pev,
    input logic       hold,
    input logic [3:0] rate,
    input logic [2:0] flags,
    input logic       alarm_evt,
    input logic       update_evt,
    input logic       bus_rd,
    input logic [3:0] bus_addr,
    input logic       irq
);
    // R5
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !pev);
    // R4
    rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 4'd0) |-> !pev);
    // R6
    alarm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> flags[1]);
    // R6
    update_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_evt |=> flags[0]);
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hC && !pev && !alarm_evt && !update_evt) |=> (flags == 3'b000));
    // R7
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |-> !irq);
endmodule

bind rtc_pi_top rtc_pi_chk u_chk (
    .clk, .rst_n, .pev, .hold, .rate, .flags,
    .alarm_evt, .update_evt, .bus_rd, .bus_addr, .irq
);

// File: tb/tb_rtc_pi_top.sv
`timescale 1ns/1ps
module tb_rtc_pi_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick_32k = 0;
    logic       alarm_evt = 0, update_evt = 0;
    logic [3:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0, bad = 0;
    bit done = 0;
    bit tick_on = 0;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    rtc_pi_top dut (.*);

    // behavioural model
    int  m_cnt = 0;
    bit  m_hold = 0, m_hold_prev = 0;
    int  m_rate = 0;
    bit [2:0] m_gate = 0, m_flags = 0;

    function automatic int period_of(int code);
        if (code == 0) return 0;
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_hold = 0; m_hold_prev = 0; m_rate = 0; m_gate = 0; m_flags = 0;
        end else begin
            bit run, pe, clr;
            int p;
            run = !m_hold && !m_hold_prev;
            p   = period_of(m_rate);
            pe  = run && tick_32k && p != 0 && ((m_cnt % p) == p - 1);
            clr = bus_rd && bus_addr == 4'hC;
            if (clr) m_flags = 3'b000;
            m_flags = m_flags | {pe, alarm_evt, update_evt};
            if (!run) m_cnt = 0;
            else if (tick_32k) m_cnt = (m_cnt + 1) % 32768;
            m_hold_prev = m_hold;
            if (bus_wr && bus_addr == 4'hA) begin m_rate = bus_wdata[3:0]; m_hold = bus_wdata[6]; end
            if (bus_wr && bus_addr == 4'hB) m_gate = bus_wdata[6:4];
            if (tick_32k) tick_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ei;
            logic [7:0] er;
            ei = |(m_flags & m_gate);
            total++;
            if (irq !== ei) begin
                bad++;
                $display("FAIL R7 irq model: got %0b exp %0b", irq, ei);
            end
            er = 8'h00;
            if (bus_rd) begin
                case (bus_addr)
                    4'hA: er = {1'b0, m_hold, 2'b00, 4'(m_rate)};
                    4'hB: er = {1'b0, m_gate, 4'h0};
                    4'hC: er = {ei, m_flags, 4'h0};
                    default: er = 8'h00;
                endcase
            end
            total++;
            if (bus_rdata !== er) begin
                bad++;
                $display("FAIL R9 rdata model addr %h: got %h exp %h", bus_addr, bus_rdata, er);
            end
        end
    end

    // time base: one-clock pulse every second clock while enabled
    initial forever begin
        @(posedge clk); #2;
        tick_32k = tick_on && !tick_32k;
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        step(); bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(); bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        step(); bus_rd = 1; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        step(); bus_rd = 0;
    endtask

    task automatic pulse_alarm();
        step(); alarm_evt = 1; step(); alarm_evt = 0;
    endtask

    task automatic pulse_update();
        step(); update_evt = 1; step(); update_evt = 0;
    endtask

    task automatic measure(int code, int exp_ticks, string tag);
        logic [7:0] d;
        int limit;
        tick_on = 0;
        wr(4'hA, 8'h40 | 8'(code));
        wr(4'hB, 8'h40);
        rd(4'hC, d);
        repeat (3) step();
        wr(4'hA, 8'(code));
        repeat (3) step();
        tick_cnt = 0;
        tick_on = 1;
        limit = 0;
        @(negedge clk);
        while (!irq && limit < 40000) begin
            @(negedge clk);
            limit++;
        end
        tick_on = 0;
        total++;
        if (tick_cnt != exp_ticks) begin
            bad++;
            $display("FAIL %s period code %0d: got %0d exp %0d", tag, code, tick_cnt, exp_ticks);
        end
        rd(4'hC, d);
        chk(tag, d, 8'hC0);
        wr(4'hA, 8'h40);
        rd(4'hC, d);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        step();
        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(4'hA, d); chk("R1 rate reg", d, 8'h00);
        rd(4'hB, d); chk("R1 gate reg", d, 8'h00);
        rd(4'hC, d); chk("R1 status", d, 8'h00);

        // R6 alarm sets flag while gated off
        pulse_alarm();
        step();
        chk("R6 irq gated", {7'b0, irq}, 8'h00);
        rd(4'hC, d); chk("R6 alarm flag", d, 8'h20);
        rd(4'hC, d); chk("R8 cleared", d, 8'h00);

        // R7 alarm permitted
        wr(4'hB, 8'h20);
        pulse_alarm();
        step();
        chk("R7 irq alarm", {7'b0, irq}, 8'h01);
        rd(4'hC, d); chk("R7 summary alarm", d, 8'hA0);
        step();
        chk("R8 irq after clear", {7'b0, irq}, 8'h00);

        // R7 update permitted, alarm gate off
        wr(4'hB, 8'h10);
        pulse_update();
        pulse_alarm();
        rd(4'hC, d); chk("R7 update summary", d, 8'hB0);

        // R8 event in the same cycle as the status read stays set
        wr(4'hB, 8'h00);
        step(); bus_rd = 1; bus_addr = 4'hC; update_evt = 1;
        @(negedge clk); d = bus_rdata;
        step(); bus_rd = 0; update_evt = 0;
        chk("R8 read before event", d, 8'h00);
        rd(4'hC, d); chk("R8 event kept", d, 8'h10);

        // R9 read-back masks and status write ignored
        wr(4'hA, 8'hFF);
        rd(4'hA, d); chk("R9 rate readback", d, 8'h4F);
        wr(4'hB, 8'hFF);
        rd(4'hB, d); chk("R9 gate readback", d, 8'h70);
        wr(4'hC, 8'hFF);
        rd(4'hC, d); chk("R9 status write ignored", d, 8'h00);
        wr(4'hB, 8'h00);

        // R5 hold keeps events away
        wr(4'hA, 8'h43);
        tick_on = 1;
        repeat (200) step();
        tick_on = 0;
        rd(4'hC, d); chk("R5 hold no event", d, 8'h00);

        // R4 code 0 never fires
        wr(4'hA, 8'h00);
        tick_on = 1;
        repeat (600) step();
        tick_on = 0;
        rd(4'hC, d); chk("R4 code zero", d, 8'h00);

        // R6 periodic flag sets with gate off
        wr(4'hA, 8'h03);
        tick_on = 1;
        repeat (20) step();
        tick_on = 0;
        step();
        chk("R6 periodic gated irq", {7'b0, irq}, 8'h00);
        rd(4'hC, d); chk("R6 periodic flag", d, 8'h40);
        wr(4'hA, 8'h40);

        // R2 and R3 periods
        measure(3, 4, "R2");
        measure(5, 16, "R2");
        measure(8, 128, "R2");
        measure(1, 128, "R3");
        measure(2, 256, "R3");
        measure(15, 16384, "R2");

        // R5 first event a full period after release
        measure(4, 8, "R5");

        repeat (4) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule